// File: doc/BRIEF.md
# Serial Port FIFO Control Unit

This unit buffers the data of a synchronous serial port between the register bus and the serial shift engine. It holds one transmit queue and one receive queue, each 32 bits wide and 16 entries deep. Words written to the port's data register are reordered by byte lane before they enter the transmit queue. Words leaving the receive queue are reordered by an independently chosen lane mode before they reach the bus read data. A control word held inside the unit selects these modes. It also holds the two trigger thresholds, the DMA request enables, a test-mode steering choice, the receive-full stall enable and a packing flag that is passed on to the shift engine.

Each queue's fill level is compared against its threshold. The result drives a receive interrupt that rises as the queue fills and a transmit interrupt that rises as the queue drains. Each interrupt is mirrored onto a DMA request through its own enable. In test mode the data register is steered to a single queue for both writes and reads, and the engine strobes are ignored. When the stall is enabled and the port is a master, a full receive queue raises a stall output that holds the serial clock, so the receive queue cannot overrun. Pushes into a full queue and pops from an empty queue are dropped, and each sets a sticky error bit that software clears by writing 1.

Top module: `spf_unit`

## Requirements
- R1: Control bits [1:0] pick the lane order for data-register writes into the transmit queue: 0 keeps the word, 1 exchanges the 16-bit halves, 2 reverses all four bytes, 3 exchanges the bytes inside each halfword, giving {w[23:16],w[31:24],w[7:0],w[15:8]}. The transmit head is shown on eng_tx_data, which is 0 when the queue is empty.
- R2: Control bits [3:2] apply the same four orders to the receive-queue head before it drives dr_rdata. dr_rdata is 0 when the queue it reads is empty.
- R3: Each queue holds 16 words in first-in first-out order and reports a 5-bit level and full and empty flags.
- R4: rx_irq is 1 exactly while the receive level is at least the control field [11:8] plus one.
- R5: tx_irq is 1 exactly while the transmit level is at most the control field [7:4] plus one.
- R6: tx_dma_req equals tx_irq when control bit 12 is 1 and is 0 otherwise. rx_dma_req equals rx_irq when bit 13 is 1 and is 0 otherwise.
- R7: With control bit 14 at 0, dr_wr pushes the transmit queue, dr_rd pops the receive queue, eng_tx_pop pops the transmit queue and eng_rx_push pushes eng_rx_data into the receive queue unchanged.
- R8: With control bit 14 at 1, bit 15 at 0 sends dr_wr and dr_rd to the transmit queue, and bit 15 at 1 sends both to the receive queue. In that case the word is stored unchanged and read with the R2 order. eng_tx_pop and eng_rx_push are ignored. A read of the transmit queue returns the stored word unchanged.
- R9: stall is 1 exactly while control bit 16 is 1, is_master is 1 and the receive queue is full.
- R10: pack_en shows control bit 17. A ctrl_we pulse loads ctrl_wdata, and the new value takes effect from the next cycle.
- R11: A push into a full queue or a pop from an empty queue leaves that queue unchanged. It sets the sticky err_flags bit: [0] transmit overrun, [1] transmit underrun, [2] receive overrun, [3] receive underrun. A 1 in err_clr clears that bit, but a new event in the same cycle wins.
- R12: After reset both queues are empty, the control word is 0 and err_flags is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_we | input | 1 | Load the control word |
| ctrl_wdata | input | 18 | New control word |
| err_clr | input | 4 | Write-1-to-clear for err_flags |
| is_master | input | 1 | Port operates as a master |
| dr_wr | input | 1 | Data-register write strobe |
| dr_wdata | input | 32 | Data-register write word |
| dr_rd | input | 1 | Data-register read strobe (pops) |
| dr_rdata | output | 32 | Data-register read word |
| eng_tx_pop | input | 1 | Shift engine takes a transmit word |
| eng_tx_data | output | 32 | Transmit queue head |
| eng_rx_push | input | 1 | Shift engine delivers a receive word |
| eng_rx_data | input | 32 | Received word |
| tx_level | output | 5 | Transmit fill level |
| rx_level | output | 5 | Receive fill level |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |
| tx_irq | output | 1 | Transmit threshold interrupt |
| rx_irq | output | 1 | Receive threshold interrupt |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |
| stall | output | 1 | Hold the master serial clock |
| pack_en | output | 1 | Packing mode to the shift engine |
| err_flags | output | 4 | Sticky overrun and underrun flags |

## Verification
The bench builds the unit with its default 32-bit word and 16-entry depth. At that depth a queue fills in 16 accesses, so full, overrun, stall and every threshold setting from 0 to 15 are all reached in short directed runs. A long random run then mixes control rewrites, test-mode steering and colliding push and pop strobes on both queues.

// File: rtl/spf_pkg.sv
package spf_pkg;

    localparam int SPF_DATA_W = 32;
    localparam int SPF_DEPTH  = 16;
    localparam int SPF_THR_W  = $clog2(SPF_DEPTH);

    typedef enum logic [1:0] {
        SWAP_NONE    = 2'd0,
        SWAP_HALVES  = 2'd1,
        SWAP_REVERSE = 2'd2,
        SWAP_IN_HALF = 2'd3
    } swap_mode_e;

    // Control word, most significant field first.
    typedef struct packed {
        logic                 pack_en;
        logic                 autofull_en;
        logic                 test_sel;
        logic                 test_en;
        logic                 rx_dma_en;
        logic                 tx_dma_en;
        logic [SPF_THR_W-1:0] rx_thr;
        logic [SPF_THR_W-1:0] tx_thr;
        swap_mode_e           rx_swap;
        swap_mode_e           tx_swap;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    localparam int ERR_TX_OVR = 0;
    localparam int ERR_TX_UND = 1;
    localparam int ERR_RX_OVR = 2;
    localparam int ERR_RX_UND = 3;
    localparam int ERR_W      = 4;

endpackage

// File: rtl/spf_lane_swap.sv
module spf_lane_swap
    import spf_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  swap_mode_e              mode,
    input  logic [4*BYTE_W-1:0]     din,
    output logic [4*BYTE_W-1:0]     dout
);
    localparam int W = 4 * BYTE_W;

    logic [BYTE_W-1:0] b [4];

    always_comb begin
        for (int i = 0; i < 4; i++) begin
            b[i] = din[i*BYTE_W +: BYTE_W];
        end
        case (mode)
            SWAP_HALVES:  dout = {b[1], b[0], b[3], b[2]};
            SWAP_REVERSE: dout = {b[0], b[1], b[2], b[3]};
            SWAP_IN_HALF: dout = {b[2], b[3], b[0], b[1]};
            default:      dout = din[W-1:0];
        endcase
    end

endmodule

// File: rtl/spf_fifo.sv
module spf_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    push,
    input  logic [DATA_W-1:0]       push_data,
    input  logic                    pop,
    output logic [DATA_W-1:0]       head,
    output logic [$clog2(DEPTH):0]  level,
    output logic                    full,
    output logic                    empty,
    output logic                    ovr_evt,
    output logic                    und_evt
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } fifo_st_t;

    fifo_st_t          st_q, st_d;
    logic [DATA_W-1:0] mem [DEPTH];
    logic              do_push, do_pop;

    always_comb begin
        st_d    = st_q;
        full    = (st_q.cnt == CNT_W'(DEPTH));
        empty   = (st_q.cnt == '0);
        do_push = push && !full;
        do_pop  = pop && !empty;
        ovr_evt = push && full;
        und_evt = pop && empty;
        if (do_push) st_d.wr = st_q.wr + PTR_W'(1);
        if (do_pop)  st_d.rd = st_q.rd + PTR_W'(1);
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + CNT_W'(1);
            2'b01:   st_d.cnt = st_q.cnt - CNT_W'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
        level = st_q.cnt;
        head  = empty ? '0 : mem[st_q.rd];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[st_q.wr] <= push_data;
    end

    // R3: the fill level never passes the depth
    a_r3_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CNT_W'(DEPTH));

    // R3: the level moves by at most one per cycle
    a_r3_level_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (level == $past(level) || level == $past(level) + CNT_W'(1)
                  || level + CNT_W'(1) == $past(level)));

    // R11: a push into a full queue without a pop is dropped
    a_r11_drop_on_full: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> full);

    // R11: a pop from an empty queue without a push is dropped
    a_r11_drop_on_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> empty);

endmodule

// File: rtl/spf_level_mon.sv
module spf_level_mon #(
    parameter int CNT_W     = 5,
    parameter int THR_W     = 4,
    parameter bit FILL_HIGH = 1'b1
) (
    input  logic [CNT_W-1:0] level,
    input  logic [THR_W-1:0] thr,
    input  logic             dma_en,
    output logic             irq,
    output logic             dma_req
);
    localparam int PAD_W = CNT_W - THR_W;

    logic [CNT_W-1:0] trig;
    logic             hit;

    assign trig = {{PAD_W{1'b0}}, thr} + CNT_W'(1);

    generate
        if (FILL_HIGH) begin : g_fill_high
            assign hit = (level >= trig);
        end else begin : g_fill_low
            assign hit = (level <= trig);
        end
    endgenerate

    assign irq     = hit;
    assign dma_req = hit && dma_en;

endmodule

// File: rtl/spf_unit.sv
module spf_unit
    import spf_pkg::*;
#(
    parameter int DATA_W = SPF_DATA_W,
    parameter int DEPTH  = SPF_DEPTH
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ctrl_we,
    input  logic [CTRL_W-1:0]       ctrl_wdata,
    input  logic [ERR_W-1:0]        err_clr,
    input  logic                    is_master,
    input  logic                    dr_wr,
    input  logic [DATA_W-1:0]       dr_wdata,
    input  logic                    dr_rd,
    output logic [DATA_W-1:0]       dr_rdata,
    input  logic                    eng_tx_pop,
    output logic [DATA_W-1:0]       eng_tx_data,
    input  logic                    eng_rx_push,
    input  logic [DATA_W-1:0]       eng_rx_data,
    output logic [$clog2(DEPTH):0]  tx_level,
    output logic [$clog2(DEPTH):0]  rx_level,
    output logic                    tx_full,
    output logic                    tx_empty,
    output logic                    rx_full,
    output logic                    rx_empty,
    output logic                    tx_irq,
    output logic                    rx_irq,
    output logic                    tx_dma_req,
    output logic                    rx_dma_req,
    output logic                    stall,
    output logic                    pack_en,
    output logic [ERR_W-1:0]        err_flags
);
    localparam int CNT_W = $clog2(DEPTH) + 1;

    typedef struct packed {
        ctrl_t            ctrl;
        logic [ERR_W-1:0] err;
    } unit_st_t;

    unit_st_t          st_q, st_d;

    logic              test_tx, test_rx;
    logic              tx_push, tx_pop, rx_push, rx_pop;
    logic [DATA_W-1:0] tx_wdata, rx_pdata, tx_head, rx_head, rx_head_sw;
    logic              tx_ovr, tx_und, rx_ovr, rx_und;

    // Data-register steering: normal mode or test-mode queue select
    always_comb begin
        test_tx  = st_q.ctrl.test_en && !st_q.ctrl.test_sel;
        test_rx  = st_q.ctrl.test_en &&  st_q.ctrl.test_sel;
        tx_push  = dr_wr && !test_rx;
        tx_pop   = st_q.ctrl.test_en ? (dr_rd && test_tx) : eng_tx_pop;
        rx_push  = st_q.ctrl.test_en ? (dr_wr && test_rx) : eng_rx_push;
        rx_pdata = st_q.ctrl.test_en ? dr_wdata : eng_rx_data;
        rx_pop   = dr_rd && !test_tx;
    end

    spf_lane_swap i_tx_swap (
        .mode (st_q.ctrl.tx_swap),
        .din  (dr_wdata),
        .dout (tx_wdata)
    );

    spf_lane_swap i_rx_swap (
        .mode (st_q.ctrl.rx_swap),
        .din  (rx_head),
        .dout (rx_head_sw)
    );

    spf_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_tx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (tx_push),
        .push_data (tx_wdata),
        .pop       (tx_pop),
        .head      (tx_head),
        .level     (tx_level),
        .full      (tx_full),
        .empty     (tx_empty),
        .ovr_evt   (tx_ovr),
        .und_evt   (tx_und)
    );

    spf_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_rx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rx_push),
        .push_data (rx_pdata),
        .pop       (rx_pop),
        .head      (rx_head),
        .level     (rx_level),
        .full      (rx_full),
        .empty     (rx_empty),
        .ovr_evt   (rx_ovr),
        .und_evt   (rx_und)
    );

    spf_level_mon #(.CNT_W(CNT_W), .THR_W(SPF_THR_W), .FILL_HIGH(1'b0)) i_tx_mon (
        .level   (tx_level),
        .thr     (st_q.ctrl.tx_thr),
        .dma_en  (st_q.ctrl.tx_dma_en),
        .irq     (tx_irq),
        .dma_req (tx_dma_req)
    );

    spf_level_mon #(.CNT_W(CNT_W), .THR_W(SPF_THR_W), .FILL_HIGH(1'b1)) i_rx_mon (
        .level   (rx_level),
        .thr     (st_q.ctrl.rx_thr),
        .dma_en  (st_q.ctrl.rx_dma_en),
        .irq     (rx_irq),
        .dma_req (rx_dma_req)
    );

    // Next state: control load and sticky error flags
    always_comb begin
        logic [ERR_W-1:0] evt;
        st_d = st_q;
        if (ctrl_we) st_d.ctrl = ctrl_t'(ctrl_wdata);
        evt = '0;
        evt[ERR_TX_OVR] = tx_ovr;
        evt[ERR_TX_UND] = tx_und;
        evt[ERR_RX_OVR] = rx_ovr;
        evt[ERR_RX_UND] = rx_und;
        st_d.err = (st_q.err & ~err_clr) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dr_rdata    = test_tx ? tx_head : rx_head_sw;
    assign eng_tx_data = tx_head;
    assign stall       = st_q.ctrl.autofull_en && is_master && rx_full;
    assign pack_en     = st_q.ctrl.pack_en;
    assign err_flags   = st_q.err;

    // R9: while stalled the receive level cannot grow
    a_r9_stall_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (rx_level <= $past(rx_level)));

    // R8: in test mode with no data-register access, neither queue moves
    a_r8_engine_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl.test_en && !dr_wr && !dr_rd && !ctrl_we)
        |=> ($stable(tx_level) && $stable(rx_level)));

    // R10: a control load shows on pack_en one cycle later
    a_r10_pack_load: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we |=> (pack_en == $past(ctrl_wdata[CTRL_W-1])));

    // R11: a set flag that is not cleared stays set
    a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((err_flags & $past(err_flags & ~err_clr)) == $past(err_flags & ~err_clr)));

endmodule

// File: tb/test_spf_unit.sv
`timescale 1ns/1ps
module test_spf_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_we = 1'b0;
    logic [17:0] ctrl_wdata = '0;
    logic [3:0]  err_clr = '0;
    logic        is_master = 1'b0;
    logic        dr_wr = 1'b0;
    logic [31:0] dr_wdata = '0;
    logic        dr_rd = 1'b0;
    logic [31:0] dr_rdata;
    logic        eng_tx_pop = 1'b0;
    logic [31:0] eng_tx_data;
    logic        eng_rx_push = 1'b0;
    logic [31:0] eng_rx_data = '0;
    logic [4:0]  tx_level, rx_level;
    logic        tx_full, tx_empty, rx_full, rx_empty;
    logic        tx_irq, rx_irq, tx_dma_req, rx_dma_req;
    logic        stall, pack_en;
    logic [3:0]  err_flags;

    always #2.5 clk = ~clk;

    spf_unit i_spf_unit (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .err_clr(err_clr), .is_master(is_master), .dr_wr(dr_wr), .dr_wdata(dr_wdata),
        .dr_rd(dr_rd), .dr_rdata(dr_rdata), .eng_tx_pop(eng_tx_pop),
        .eng_tx_data(eng_tx_data), .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
        .tx_level(tx_level), .rx_level(rx_level), .tx_full(tx_full), .tx_empty(tx_empty),
        .rx_full(rx_full), .rx_empty(rx_empty), .tx_irq(tx_irq), .rx_irq(rx_irq),
        .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req), .stall(stall),
        .pack_en(pack_en), .err_flags(err_flags)
    );

    // Reference model
    bit [31:0] txq[$];
    bit [31:0] rxq[$];
    bit [17:0] m_ctrl;
    bit [3:0]  m_err;

    int    n_vec = 0;
    int    n_bad = 0;
    string phase = "R12 reset";

    function automatic bit [31:0] ref_swap(bit [31:0] w, int mode);
        bit [7:0] b[4];
        int       src[4];
        for (int i = 0; i < 4; i++) b[i] = w[8*i +: 8];
        case (mode)
            1: src = '{1, 0, 3, 2};
            2: src = '{0, 1, 2, 3};
            3: src = '{2, 3, 0, 1};
            default: src = '{3, 2, 1, 0};
        endcase
        return {b[src[0]], b[src[1]], b[src[2]], b[src[3]]};
    endfunction

    function automatic bit [17:0] mk_ctrl(int txs, int rxs, int txt, int rxt, bit txd, bit rxd,
                                         bit te, bit ts, bit af, bit pk);
        return {pk, af, ts, te, rxd, txd, 4'(rxt), 4'(txt), 2'(rxs), 2'(txs)};
    endfunction

    task automatic model_update();
        bit te, ts, txpu, txpo, rxpu, rxpo;
        bit [31:0] txd, rxd;
        bit [3:0] ev;
        te   = m_ctrl[14];
        ts   = m_ctrl[15];
        txpu = dr_wr && !(te && ts);
        txd  = ref_swap(dr_wdata, int'(m_ctrl[1:0]));
        txpo = te ? (dr_rd && !ts) : eng_tx_pop;
        rxpu = te ? (dr_wr && ts) : eng_rx_push;
        rxd  = te ? dr_wdata : eng_rx_data;
        rxpo = dr_rd && !(te && !ts);
        ev   = '0;
        ev[0] = txpu && txq.size() == 16;
        ev[1] = txpo && txq.size() == 0;
        ev[2] = rxpu && rxq.size() == 16;
        ev[3] = rxpo && rxq.size() == 0;
        if (txpo && !ev[1]) void'(txq.pop_front());
        if (txpu && !ev[0]) txq.push_back(txd);
        if (rxpo && !ev[3]) void'(rxq.pop_front());
        if (rxpu && !ev[2]) rxq.push_back(rxd);
        m_err = (m_err & ~err_clr) | ev;
        if (ctrl_we) m_ctrl = ctrl_wdata;
    endtask

    task automatic chk(string req, string name, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s [%s] %s: actual=%h expected=%h", req, phase, name, act, exp);
        end
    endtask

    task automatic compare();
        int txl, rxl;
        bit [31:0] e_rd;
        txl = txq.size();
        rxl = rxq.size();
        if (m_ctrl[14] && !m_ctrl[15]) e_rd = (txl != 0) ? txq[0] : 32'h0;
        else e_rd = (rxl != 0) ? ref_swap(rxq[0], int'(m_ctrl[3:2])) : 32'h0;
        chk("R3", "tx_level", 32'(tx_level), 32'(txl));
        chk("R3", "rx_level", 32'(rx_level), 32'(rxl));
        chk("R3", "tx_full/empty", {30'b0, tx_full, tx_empty}, {30'b0, txl == 16, txl == 0});
        chk("R3", "rx_full/empty", {30'b0, rx_full, rx_empty}, {30'b0, rxl == 16, rxl == 0});
        chk("R1", "eng_tx_data", eng_tx_data, (txl != 0) ? txq[0] : 32'h0);
        chk("R2", "dr_rdata", dr_rdata, e_rd);
        chk("R4", "rx_irq", 32'(rx_irq), 32'(rxl >= int'(m_ctrl[11:8]) + 1));
        chk("R5", "tx_irq", 32'(tx_irq), 32'(txl <= int'(m_ctrl[7:4]) + 1));
        chk("R6", "tx_dma_req", 32'(tx_dma_req), 32'(m_ctrl[12] && txl <= int'(m_ctrl[7:4]) + 1));
        chk("R6", "rx_dma_req", 32'(rx_dma_req), 32'(m_ctrl[13] && rxl >= int'(m_ctrl[11:8]) + 1));
        chk("R9", "stall", 32'(stall), 32'(m_ctrl[16] && is_master && rxl == 16));
        chk("R10", "pack_en", 32'(pack_en), 32'(m_ctrl[17]));
        chk("R11", "err_flags", 32'(err_flags), 32'(m_err));
    endtask

    // One clock: inputs already driven; model follows the edge, compare mid-cycle
    task automatic step();
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare();
        ctrl_we = 0; err_clr = '0; dr_wr = 0; dr_rd = 0; eng_tx_pop = 0; eng_rx_push = 0;
    endtask

    task automatic wr_ctrl(bit [17:0] v);
        ctrl_we = 1; ctrl_wdata = v; step();
    endtask
    task automatic bus_write(bit [31:0] d);
        dr_wr = 1; dr_wdata = d; step();
    endtask
    task automatic bus_read();
        dr_rd = 1; step();
    endtask
    task automatic eng_pop();
        eng_tx_pop = 1; step();
    endtask
    task automatic eng_push(bit [31:0] d);
        eng_rx_push = 1; eng_rx_data = d; step();
    endtask
    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R12 watchdog: actual=timeout expected=finish within 100000 cycles");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        compare();                      // R12 reset state
        rst_n = 1;
        step();

        phase = "R1 tx lane order";
        for (int m = 0; m < 4; m++) begin
            wr_ctrl(mk_ctrl(m, 0, 0, 0, 0, 0, 0, 0, 0, 0));
            bus_write(32'h11223344 + 32'(m));
            eng_pop();
        end

        phase = "R3 R11 tx fill overrun underrun";
        wr_ctrl(mk_ctrl(0, 0, 15, 0, 1, 0, 0, 0, 0, 0));
        for (int i = 0; i < 16; i++) bus_write(32'hA000_0000 + 32'(i));
        dr_wr = 1; dr_wdata = 32'hDEAD_BEEF; err_clr = 4'b0001; step();  // set wins over clear
        err_clr = 4'b0001; step();
        for (int i = 0; i < 17; i++) eng_pop();
        err_clr = 4'b1111; step();

        phase = "R2 R7 rx lane order";
        for (int m = 0; m < 4; m++) begin
            wr_ctrl(mk_ctrl(0, m, 0, 0, 0, 0, 0, 0, 0, 0));
            eng_push(32'hA1B2C3D4 ^ 32'(m));
            bus_read();
        end
        bus_read();                     // R11 rx underrun
        err_clr = 4'b1000; step();

        phase = "R4 R5 R6 thresholds";
        wr_ctrl(mk_ctrl(0, 0, 2, 3, 1, 1, 0, 0, 0, 0));
        for (int i = 0; i < 7; i++) begin
            eng_push(32'(i));
            bus_write(32'(i) << 4);
        end
        wr_ctrl(mk_ctrl(0, 0, 6, 0, 0, 0, 0, 0, 0, 0));
        for (int i = 0; i < 8; i++) begin
            bus_read();
            eng_pop();
        end

        phase = "R9 stall";
        is_master = 1;
        wr_ctrl(mk_ctrl(0, 0, 0, 15, 0, 1, 0, 0, 1, 0));
        for (int i = 0; i < 17; i++) eng_push(32'hC0DE_0000 + 32'(i));
        is_master = 0; step();
        is_master = 1; step();
        bus_read();
        for (int i = 0; i < 16; i++) bus_read();
        err_clr = 4'b1111; step();

        phase = "R8 test mode tx select";
        wr_ctrl(mk_ctrl(1, 2, 0, 0, 0, 0, 1, 0, 0, 0));
        dr_wr = 1; dr_wdata = 32'h0102_0304; eng_tx_pop = 1; eng_rx_push = 1; eng_rx_data = 32'h5; step();
        eng_tx_pop = 1; eng_rx_push = 1; step();
        bus_read();
        phase = "R8 test mode rx select";
        wr_ctrl(mk_ctrl(1, 2, 0, 0, 0, 0, 1, 1, 0, 0));
        dr_wr = 1; dr_wdata = 32'h0A0B_0C0D; eng_rx_push = 1; eng_rx_data = 32'h7; step();
        eng_tx_pop = 1; eng_rx_push = 1; step();
        bus_read();

        phase = "R10 pack flag";
        wr_ctrl(mk_ctrl(0, 0, 0, 0, 0, 0, 0, 0, 0, 1));
        step();
        wr_ctrl(mk_ctrl(0, 0, 0, 0, 0, 0, 0, 0, 0, 0));

        phase = "R1 R2 R7 R8 R11 random mix";
        for (int c = 0; c < 4000; c++) begin
            if ($urandom_range(0, 31) == 0) begin
                ctrl_we = 1;
                ctrl_wdata = 18'($urandom);
                if ($urandom_range(0, 3) != 0) ctrl_wdata[14] = 0;
            end
            if ($urandom_range(0, 15) == 0) err_clr = 4'($urandom);
            is_master   = 1'($urandom);
            dr_wr       = ($urandom_range(0, 2) == 0);
            dr_wdata    = $urandom;
            dr_rd       = ($urandom_range(0, 2) == 0);
            eng_tx_pop  = ($urandom_range(0, 2) == 0);
            eng_rx_push = ($urandom_range(0, 2) == 0);
            eng_rx_data = $urandom;
            step();
        end

        finish_run();
    end

endmodule